// File: doc/BRIEF.md
# Sixteen-Register Byte-Coded Interpreter Core

This block is a compact multi-cycle processor that runs a 16-bit register-machine instruction set coded in bytes. It fetches instructions of one to three bytes from a byte-addressed 64 KB space through a single synchronous memory port. The port has one address bus, one read-data byte, one write-data byte and a write strobe. Read data is valid one cycle after the address is presented.

All architectural state is held in sixteen 16-bit registers. Four of them have fixed roles. Register 15 is the program counter. Register 12 is the call stack pointer. Register 13 receives compare results. Register 14 holds status: the carry bit and the number of the register that took the last result. Conditional branches test the register named by the status word, so a branch needs no explicit operand.

Each instruction passes through fetch and decode, then one read step per operand or data byte, one write step per stored byte, and a single execute step that retires every register update. The break opcode stops the core and raises `halt_o`.

Top module: `s16_core`

## Requirements
- R1: While `rst_ni` is low, and after it is released, every register reads zero, `halt_o` and `mem_we_o` are low, and the first fetch is from address 0x0000.
- R2: Opcode 0x1n followed by a low byte and then a high byte loads the 16-bit constant into register n and moves the program counter past all three bytes. A destination of 15 therefore acts as a jump.
- R3: Opcode 0x2n copies register n into R0 and records R0 as the last result. Opcode 0x3n copies R0 into register n and records n as the last result.
- R4: Opcode 0x4n loads the byte at the address in register n into R0, zero-extended, and then adds 1 to register n. Opcode 0x5n stores the low byte of R0 at that address and adds 1 to register n, leaving the status unchanged. When n is 0, the loaded value wins over the pointer update.
- R5: Opcodes 0x6n and 0x7n load or store a 16-bit word through register n, low byte at the lower address, and add 2 to register n.
- R6: Opcode 0x8n sets R0 to R0 + Rn and opcode 0x9n sets R0 to R0 − Rn, both modulo 2^16. The carry is the adder carry-out, or "no borrow" (R0 ≥ Rn) for subtraction. R0 is recorded as the last result.
- R7: Opcode 0xAn writes R0 − Rn to R13, sets the carry as for subtraction, records 13 as the last result and leaves R0 unchanged.
- R8: Opcodes 0xBn and 0xCn add 1 to or subtract 1 from register n with wraparound. They record n as the last result and keep the carry.
- R9: Any instruction that records a last result rewrites R14 to {7'b0, carry, 4'b0, index}, with the carry at bit 8 and the index in bits 3:0. The rewrite is skipped when that result register is R14 itself.
- R10: Opcodes 0x02 to 0x0A are two-byte branches: always, carry clear, carry set, plus, minus, zero, nonzero, equal to 0xFFFF, and not equal to 0xFFFF. A branch tests the register indexed by R14[3:0] and the carry in R14[8]. The signed displacement (−128..+127) is added to the address that follows the branch.
- R11: Opcode 0x0B (call, with a displacement) stores the return address low byte at R12 and high byte at R12+1, adds 2 to R12, and branches. Opcode 0x01 (return) subtracts 2 from R12 and loads the program counter from the word stored there.
- R12: Opcode 0x00 raises `halt_o`, which stays high until reset, and no memory write occurs afterwards. Opcodes 0x0C–0x0F and 0xD0–0xFF are one-byte no-operations.
- R13: An instruction takes 3 + 2×(bytes read after the opcode) + (bytes written) cycles, and the break opcode reaches halt 2 cycles after its fetch begins.
- R14: A store drives address and data with `mem_we_o` high for one cycle per byte, and a word's two bytes go to consecutive addresses in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 16 | Byte address for reads and writes |
| mem_rdata_i | input | 8 | Read data, valid one cycle after the address |
| mem_wdata_o | output | 8 | Write data byte |
| mem_we_o | output | 1 | Write strobe |
| halt_o | output | 1 | High once the break opcode has executed |

## Verification
Registers can only be observed through the bytes the core stores and the cycle in which it halts, so a wrong internal value stays hidden until a store or a branch depends on it. A bad pointer or stack update shows at once as a wrong address on the next store. A wrong status word or wrong carry only shows after a later branch, as a different path, which surfaces as a shifted halt cycle or a store that is missing or extra. For this reason the test programs copy R13, R14 and incremented pointers to memory right after the instruction that produces them. The bench compares every write strobe and the halt level on every cycle against an instruction-level model, so a divergence is reported within a few cycles of the instruction that caused it.

// File: rtl/s16_pkg.sv
package s16_pkg;
  localparam int W    = 16;
  localparam int NREG = 16;
  localparam int NWP  = 4;               // write ports: pointer, stack, status, result
  localparam int IW   = $clog2(NREG);

  localparam int P_PTR = 0;
  localparam int P_STK = 1;
  localparam int P_STS = 2;
  localparam int P_RES = 3;

  localparam logic [IW-1:0] R_SP  = IW'(12);
  localparam logic [IW-1:0] R_CMP = IW'(13);
  localparam logic [IW-1:0] R_STS = IW'(14);
  localparam logic [IW-1:0] R_PC  = IW'(15);

  localparam logic [3:0] OP_SYS = 4'h0;
  localparam logic [3:0] OP_SET = 4'h1;
  localparam logic [3:0] OP_LD  = 4'h2;
  localparam logic [3:0] OP_ST  = 4'h3;
  localparam logic [3:0] OP_LDB = 4'h4;
  localparam logic [3:0] OP_STB = 4'h5;
  localparam logic [3:0] OP_LDW = 4'h6;
  localparam logic [3:0] OP_STW = 4'h7;
  localparam logic [3:0] OP_ADD = 4'h8;
  localparam logic [3:0] OP_SUB = 4'h9;
  localparam logic [3:0] OP_CMP = 4'hA;
  localparam logic [3:0] OP_INC = 4'hB;
  localparam logic [3:0] OP_DEC = 4'hC;

  localparam logic [3:0] SY_BRK  = 4'h0;
  localparam logic [3:0] SY_RET  = 4'h1;
  localparam logic [3:0] SY_CALL = 4'hB;

  typedef enum logic [2:0] {S_FETCH, S_DEC, S_RD, S_CAP, S_WR, S_EXE, S_HALT} state_e;
  typedef enum logic [1:0] {B_PC, B_REG, B_SPM2} base_e;

  typedef struct packed {
    logic [1:0] nrd;
    logic [1:0] nwr;
    base_e      rbase;
  } ctl_t;

  function automatic ctl_t decode(input logic [7:0] op);
    ctl_t c;
    c       = '0;
    c.rbase = B_PC;
    case (op[7:4])
      OP_SYS: begin
        if (op[3:0] == SY_RET) begin
          c.nrd   = 2'd2;
          c.rbase = B_SPM2;
        end else if (op[3:0] == SY_CALL) begin
          c.nrd = 2'd1;
          c.nwr = 2'd2;
        end else if (op[3:0] >= 4'h2 && op[3:0] <= 4'hA) begin
          c.nrd = 2'd1;
        end
      end
      OP_SET: c.nrd = 2'd2;
      OP_LDB: begin c.nrd = 2'd1; c.rbase = B_REG; end
      OP_LDW: begin c.nrd = 2'd2; c.rbase = B_REG; end
      OP_STB: c.nwr = 2'd1;
      OP_STW: c.nwr = 2'd2;
      default: ;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/s16_regfile.sv
module s16_regfile #(
  parameter int NREG = 16,
  parameter int W    = 16,
  parameter int NWP  = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NWP-1:0]                  we_i,
  input  logic [NWP-1:0][$clog2(NREG)-1:0] idx_i,
  input  logic [NWP-1:0][W-1:0]           dat_i,
  output logic [NREG-1:0][W-1:0]          regs_o
);
  logic [NREG-1:0][W-1:0] regs_q;

  // higher port index wins on the same register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else begin
      for (int p = 0; p < NWP; p++) begin
        if (we_i[p]) regs_q[idx_i[p]] <= dat_i[p];
      end
    end
  end

  assign regs_o = regs_q;
endmodule

// File: rtl/s16_addsub.sv
module s16_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  logic [W:0] full;
  logic [W-1:0] b_eff;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign full  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
  assign sum_o   = full[W-1:0];
  assign carry_o = full[W];
endmodule

// File: rtl/s16_cond.sv
module s16_cond #(
  parameter int W = 16
) (
  input  logic [3:0]   cond_i,
  input  logic [W-1:0] last_i,
  input  logic         carry_i,
  output logic         take_o
);
  always_comb begin
    case (cond_i)
      4'h2:    take_o = 1'b1;
      4'h3:    take_o = !carry_i;
      4'h4:    take_o = carry_i;
      4'h5:    take_o = !last_i[W-1];
      4'h6:    take_o = last_i[W-1];
      4'h7:    take_o = (last_i == '0);
      4'h8:    take_o = (last_i != '0);
      4'h9:    take_o = (last_i == '1);
      4'hA:    take_o = (last_i != '1);
      4'hB:    take_o = 1'b1;
      default: take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/s16_core.sv
module s16_core
  import s16_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic [15:0] mem_addr_o,
  input  logic [7:0]  mem_rdata_i,
  output logic [7:0]  mem_wdata_o,
  output logic        mem_we_o,
  output logic        halt_o
);
  state_e st_q;
  logic [7:0]   ir_q;
  logic [1:0]   cnt_q;
  logic [W-1:0] dbuf_q;
  ctl_t ctl_d, ctl;

  logic [NREG-1:0][W-1:0] regs;
  logic [NWP-1:0]          wen;
  logic [NWP-1:0][IW-1:0]  widx;
  logic [NWP-1:0][W-1:0]   wdat;

  logic [IW-1:0] rn;
  logic [W-1:0]  rv, disp, rbase, wbase, wsrc, alu_sum;
  logic          alu_c, take, is_call;

  assign ctl_d   = decode(mem_rdata_i);
  assign ctl     = decode(ir_q);
  assign rn      = ir_q[IW-1:0];
  assign rv      = regs[rn];
  assign disp    = {{(W-8){dbuf_q[7]}}, dbuf_q[7:0]};
  assign is_call = (ir_q == {OP_SYS, SY_CALL});

  s16_regfile #(.NREG(NREG), .W(W), .NWP(NWP)) u_rf (
    .clk_i, .rst_ni, .we_i(wen), .idx_i(widx), .dat_i(wdat), .regs_o(regs)
  );

  s16_addsub #(.W(W)) u_alu (
    .a_i(regs[0]), .b_i(rv), .sub_i(ir_q[7:4] != OP_ADD),
    .sum_o(alu_sum), .carry_o(alu_c)
  );

  s16_cond #(.W(W)) u_cond (
    .cond_i(ir_q[3:0]), .last_i(regs[regs[R_STS][IW-1:0]]),
    .carry_i(regs[R_STS][8]), .take_o(take)
  );

  // memory port
  always_comb begin
    case (ctl.rbase)
      B_REG:   rbase = rv;
      B_SPM2:  rbase = regs[R_SP] - W'(2);
      default: rbase = regs[R_PC];
    endcase
    wbase = is_call ? regs[R_SP] : rv;
    wsrc  = is_call ? regs[R_PC] + W'(1) : regs[0];
    case (st_q)
      S_RD:    mem_addr_o = rbase + W'(cnt_q);
      S_WR:    mem_addr_o = wbase + W'(cnt_q);
      default: mem_addr_o = regs[R_PC];
    endcase
    mem_wdata_o = cnt_q[0] ? wsrc[15:8] : wsrc[7:0];
  end
  assign mem_we_o = (st_q == S_WR);
  assign halt_o   = (st_q == S_HALT);

  // sequencer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_FETCH;
      ir_q   <= '0;
      cnt_q  <= '0;
      dbuf_q <= '0;
    end else begin
      case (st_q)
        S_FETCH: st_q <= S_DEC;
        S_DEC: begin
          ir_q   <= mem_rdata_i;
          cnt_q  <= '0;
          dbuf_q <= '0;
          if (mem_rdata_i == {OP_SYS, SY_BRK}) st_q <= S_HALT;
          else if (ctl_d.nrd != '0)            st_q <= S_RD;
          else if (ctl_d.nwr != '0)            st_q <= S_WR;
          else                                 st_q <= S_EXE;
        end
        S_RD: st_q <= S_CAP;
        S_CAP: begin
          if (cnt_q[0]) dbuf_q[15:8] <= mem_rdata_i;
          else          dbuf_q[7:0]  <= mem_rdata_i;
          if (cnt_q + 2'd1 == ctl.nrd) begin
            cnt_q <= '0;
            st_q  <= (ctl.nwr != '0) ? S_WR : S_EXE;
          end else begin
            cnt_q <= cnt_q + 2'd1;
            st_q  <= S_RD;
          end
        end
        S_WR: begin
          if (cnt_q + 2'd1 == ctl.nwr) begin
            cnt_q <= '0;
            st_q  <= S_EXE;
          end else begin
            cnt_q <= cnt_q + 2'd1;
          end
        end
        S_EXE:   st_q <= S_FETCH;
        default: st_q <= S_HALT;
      endcase
    end
  end

  // register updates
  logic          sflag, setc, res_en;
  logic [IW-1:0] dest;
  logic [W-1:0]  res_v;

  always_comb begin
    wen    = '0;
    widx   = '0;
    wdat   = '0;
    sflag  = 1'b0;
    setc   = 1'b0;
    res_en = 1'b0;
    dest   = '0;
    res_v  = '0;
    if (st_q == S_FETCH) begin
      wen[P_PTR]  = 1'b1;
      widx[P_PTR] = R_PC;
      wdat[P_PTR] = regs[R_PC] + W'(1);
    end else if (st_q == S_EXE) begin
      case (ir_q[7:4])
        OP_SYS: begin
          if (ir_q[3:0] == SY_RET) begin
            wen[P_PTR] = 1'b1; widx[P_PTR] = R_PC; wdat[P_PTR] = dbuf_q;
            wen[P_STK] = 1'b1; widx[P_STK] = R_SP; wdat[P_STK] = regs[R_SP] - W'(2);
          end else if (ctl.nrd != '0) begin
            wen[P_PTR]  = 1'b1;
            widx[P_PTR] = R_PC;
            wdat[P_PTR] = regs[R_PC] + W'(1) + (take ? disp : '0);
            if (is_call) begin
              wen[P_STK] = 1'b1; widx[P_STK] = R_SP; wdat[P_STK] = regs[R_SP] + W'(2);
            end
          end
        end
        OP_SET: begin
          wen[P_PTR] = 1'b1; widx[P_PTR] = R_PC; wdat[P_PTR] = regs[R_PC] + W'(2);
          sflag = 1'b1; res_en = 1'b1; dest = rn; res_v = dbuf_q;
        end
        OP_LD: begin sflag = 1'b1; res_en = 1'b1; dest = '0; res_v = rv; end
        OP_ST: begin sflag = 1'b1; res_en = 1'b1; dest = rn; res_v = regs[0]; end
        OP_LDB, OP_LDW, OP_STB, OP_STW: begin
          wen[P_PTR]  = 1'b1;
          widx[P_PTR] = rn;
          wdat[P_PTR] = rv + W'(ir_q[5] ? 2 : 1);
          if (!ir_q[4]) begin
            sflag = 1'b1; res_en = 1'b1; dest = '0; res_v = dbuf_q;
          end
        end
        OP_ADD, OP_SUB: begin sflag = 1'b1; setc = 1'b1; res_en = 1'b1; dest = '0;    res_v = alu_sum; end
        OP_CMP:         begin sflag = 1'b1; setc = 1'b1; res_en = 1'b1; dest = R_CMP; res_v = alu_sum; end
        OP_INC: begin sflag = 1'b1; res_en = 1'b1; dest = rn; res_v = rv + W'(1); end
        OP_DEC: begin sflag = 1'b1; res_en = 1'b1; dest = rn; res_v = rv - W'(1); end
        default: ;
      endcase
    end
    wen[P_STS]  = sflag && (dest != R_STS);
    widx[P_STS] = R_STS;
    wdat[P_STS] = {7'b0, setc ? alu_c : regs[R_STS][8], 4'b0, dest};
    wen[P_RES]  = res_en;
    widx[P_RES] = dest;
    wdat[P_RES] = res_v;
  end
endmodule

// File: rtl/s16_core_chk.sv
module s16_core_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] mem_addr_o,
  input logic        mem_we_o,
  input logic        halt_o
);
  // R1
  first_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (mem_addr_o == 16'h0000) && !halt_o && !mem_we_o);

  // R12
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);

  // R12
  halt_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !mem_we_o);

  // R12
  halt_addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> $stable(mem_addr_o));

  // R14
  word_consec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) + 16'd1));

  // R14
  write_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |=> !mem_we_o);
endmodule

bind s16_core s16_core_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_addr_o(mem_addr_o),
  .mem_we_o(mem_we_o), .halt_o(halt_o)
);

// File: tb/s16_core_tb_top.sv
`timescale 1ns/1ps
module s16_core_tb_top;
  localparam int MSZ = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic        halt;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  s16_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .mem_wdata_o(mem_wdata), .mem_we_o(mem_we), .halt_o(halt)
  );

  // bench memory; loaded through its own port
  logic [7:0]  dm [MSZ];
  logic        clr_en = 1'b0;
  logic        ld_en = 1'b0;
  logic [11:0] ld_addr = '0;
  logic [7:0]  ld_dat = '0;

  always @(posedge clk) begin
    if (clr_en) begin
      for (int i = 0; i < MSZ; i++) dm[i] <= 8'h00;
    end else if (ld_en) begin
      dm[ld_addr] <= ld_dat;
    end else if (mem_we) begin
      dm[mem_addr[11:0]] <= mem_wdata;
    end
    mem_rdata <= dm[mem_addr[11:0]];
  end

  // reference model state
  logic [7:0]  mm [MSZ];
  logic [23:0] exp_wr [$];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic mem_clear();
    for (int i = 0; i < MSZ; i++) mm[i] = 8'h00;
    @(negedge clk); clr_en = 1'b1;
    @(negedge clk); clr_en = 1'b0;
  endtask

  task automatic put(input int base, input logic [7:0] b[$]);
    foreach (b[i]) begin
      mm[(base + i) % MSZ] = b[i];
      ld_addr = 12'((base + i) % MSZ);
      ld_dat  = b[i];
      ld_en   = 1'b1;
      @(negedge clk);
    end
    ld_en = 1'b0;
  endtask

  function automatic int rdm(input int a);
    return int'(mm[(a & 16'hFFFF) % MSZ]);
  endfunction

  function automatic void wrm(input int a, input int d);
    mm[(a & 16'hFFFF) % MSZ] = 8'(d);
    exp_wr.push_back({16'(a), 8'(d)});
  endfunction

  // instruction-level model: returns cycles until halt
  task automatic model_run(output int tot);
    int r [16];
    int op, hi, n, c, v, p, s, d, last, cy, st_keep;
    bit tk;
    for (int i = 0; i < 16; i++) r[i] = 0;
    exp_wr.delete();
    tot = 0;
    for (int step = 0; step < 4000; step++) begin
      op = rdm(r[15]);
      r[15] = (r[15] + 1) & 16'hFFFF;
      hi = op >> 4; n = op & 15;
      c = (r[14] >> 8) & 1;
      st_keep = -1; cy = 0;
      if (op == 0) begin tot += 2; return; end
      case (hi)
        0: begin
          if (n == 1) begin
            p = (r[12] - 2) & 16'hFFFF;
            v = rdm(p) | (rdm(p + 1) << 8); cy = 4;
            r[12] = p; r[15] = v;
          end else if (n >= 2 && n <= 11) begin
            d = rdm(r[15]); if (d > 127) d -= 256; cy = 2;
            last = r[r[14] & 15];
            case (n)
              3: tk = (c == 0);
              4: tk = (c == 1);
              5: tk = (last & 16'h8000) == 0;
              6: tk = (last & 16'h8000) != 0;
              7: tk = (last == 0);
              8: tk = (last != 0);
              9: tk = (last == 16'hFFFF);
              10: tk = (last != 16'hFFFF);
              default: tk = 1;
            endcase
            v = (r[15] + 1) & 16'hFFFF;
            if (n == 11) begin
              wrm(r[12], v & 255); wrm(r[12] + 1, v >> 8); cy = 4;
              r[12] = (r[12] + 2) & 16'hFFFF;
            end
            r[15] = tk ? ((v + d) & 16'hFFFF) : v;
          end
        end
        1: begin
          v = rdm(r[15]) | (rdm(r[15] + 1) << 8); cy = 4;
          r[15] = (r[15] + 2) & 16'hFFFF;
          if (n != 14) r[14] = (c << 8) | n;
          r[n] = v;
        end
        2: begin v = r[n]; r[14] = (c << 8); r[0] = v; end
        3: begin v = r[0]; if (n != 14) r[14] = (c << 8) | n; r[n] = v; end
        4, 6: begin
          p = r[n];
          if (hi == 4) begin v = rdm(p); cy = 2; r[n] = (p + 1) & 16'hFFFF; end
          else begin v = rdm(p) | (rdm(p + 1) << 8); cy = 4; r[n] = (p + 2) & 16'hFFFF; end
          r[14] = (c << 8); r[0] = v;
        end
        5: begin p = r[n]; wrm(p, r[0] & 255); cy = 1; r[n] = (p + 1) & 16'hFFFF; end
        7: begin p = r[n]; wrm(p, r[0] & 255); wrm(p + 1, r[0] >> 8); cy = 2; r[n] = (p + 2) & 16'hFFFF; end
        8: begin s = r[0] + r[n]; r[14] = ((s >> 16) & 1) << 8; r[0] = s & 16'hFFFF; end
        9, 10: begin
          s = r[0] + ((~r[n]) & 16'hFFFF) + 1;
          if (hi == 9) begin r[14] = ((s >> 16) & 1) << 8; r[0] = s & 16'hFFFF; end
          else begin r[14] = (((s >> 16) & 1) << 8) | 13; r[13] = s & 16'hFFFF; end
        end
        11, 12: begin
          v = (hi == 11) ? (r[n] + 1) & 16'hFFFF : (r[n] - 1) & 16'hFFFF;
          if (n != 14) r[14] = (c << 8) | n;
          r[n] = v;
        end
        default: ;
      endcase
      tot += 3 + cy;
    end
    tot = 1000000;
  endtask

  task automatic run_prog(input string name, input int lo, input int hi_a);
    int tot;
    logic [23:0] e;
    model_run(tot);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 1; k <= tot + 4; k++) begin
      @(negedge clk);
      if (mem_we) begin
        if (exp_wr.size() == 0) begin
          chk("R12", {name, " unexpected write"}, {8'h0, mem_addr, mem_wdata}, 32'hFFFFFFFF);
        end else begin
          e = exp_wr.pop_front();
          chk("R14", {name, " write addr/data"}, {8'h0, mem_addr, mem_wdata}, {8'h0, e});
        end
      end
      chk("R13", {name, " halt level"}, 32'(halt), 32'(k >= tot));
    end
    chk("R14", {name, " pending writes"}, 32'(exp_wr.size()), 32'd0);
    for (int a = lo; a < hi_a; a++) chk("R14", {name, " memory image"}, 32'(dm[a]), 32'(mm[a]));
  endtask

  function automatic logic [15:0] w16(input int a);
    return {dm[a + 1], dm[a]};
  endfunction

  task automatic start_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "halt in reset", 32'(halt), 32'd0);
    chk("R1", "we in reset", 32'(mem_we), 32'd0);
    chk("R1", "fetch address in reset", 32'(mem_addr), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected halt");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);

    // P1: set, copy, add/sub, compare, status readback
    start_reset();
    mem_clear();
    put(0, '{8'h11, 8'h34, 8'h12, 8'h12, 8'hF0, 8'hFF, 8'h13, 8'h00, 8'h08,
             8'h21, 8'h82, 8'h73, 8'h2E, 8'h73, 8'h21, 8'h92, 8'h73, 8'h2E,
             8'h73, 8'hA1, 8'h2E, 8'h73, 8'h2D, 8'h73, 8'h00});
    run_prog("P1", 16'h800, 16'h810);
    chk("R6", "add sum", 32'(w16(16'h800)), 32'h1224);
    chk("R9", "status after add carry", 32'(w16(16'h802)), 32'h0100);
    chk("R6", "sub difference", 32'(w16(16'h804)), 32'h1244);
    chk("R9", "status after sub borrow", 32'(w16(16'h806)), 32'h0000);
    chk("R7", "status after compare", 32'(w16(16'h808)), 32'h000D);
    chk("R7", "compare result in R13", 32'(w16(16'h80A)), 32'hEDCC);
    chk("R3", "copy R1 to R0", 32'(w16(16'h800)) - 32'hFFF0 + 32'h10000, 32'h1234);

    // P2: byte and word indirect, inc/dec wrap
    start_reset();
    mem_clear();
    put(16'h900, '{8'h9C, 8'h41, 8'h80});
    put(16'hA08, '{8'hEE});
    put(0, '{8'h14, 8'h00, 8'h09, 8'h15, 8'h00, 8'h0A, 8'h44, 8'h55, 8'h44, 8'h55,
             8'h16, 8'hFF, 8'hFF, 8'hB6, 8'h26, 8'h55, 8'hC6, 8'h26, 8'h75,
             8'h25, 8'h75, 8'h44, 8'h75, 8'h00});
    run_prog("P2", 16'hA00, 16'hA10);
    chk("R4", "byte copy 0", 32'(dm[16'hA00]), 32'h9C);
    chk("R4", "byte copy 1", 32'(dm[16'hA01]), 32'h41);
    chk("R8", "inc wrap to zero", 32'(dm[16'hA02]), 32'h00);
    chk("R8", "dec wrap to ffff", 32'(w16(16'hA03)), 32'hFFFF);
    chk("R5", "pointer advanced by word stores", 32'(w16(16'hA05)), 32'h0A05);
    chk("R4", "byte load zero-extends", 32'(w16(16'hA07)), 32'h0080);

    // P3: loop with call/return, backward and forward branches
    start_reset();
    mem_clear();
    put(0, '{8'h11, 8'h03, 8'h00, 8'h17, 8'h00, 8'h0B, 8'h1C, 8'h00, 8'h0C,
             8'hC1, 8'h0B, 8'h14, 8'h21, 8'h08, 8'hFA, 8'h07, 8'h02, 8'h00, 8'h00,
             8'h19, 8'hFF, 8'hFF, 8'h09, 8'h02, 8'h00, 8'h00, 8'h05, 8'h02, 8'h00});
    put(16'h20, '{8'h21, 8'h57, 8'h01});
    run_prog("P3", 16'hB00, 16'hC04);
    chk("R11", "subroutine pass 1", 32'(dm[16'hB00]), 32'h02);
    chk("R10", "loop pass 2 via backward branch", 32'(dm[16'hB01]), 32'h01);
    chk("R10", "loop pass 3", 32'(dm[16'hB02]), 32'h00);
    chk("R11", "return address on stack", 32'(w16(16'hC00)), 32'h000C);
    chk("R11", "stack restored by return", 32'(w16(16'hC02)), 32'h0000);

    // P4: status write suppression, carry branches, no-ops, jump through R15
    start_reset();
    mem_clear();
    put(0, '{8'h1E, 8'h00, 8'h01, 8'h04, 8'h02, 8'h00, 8'h00, 8'h03, 8'h02,
             8'hD3, 8'h0C, 8'h2E, 8'h1F, 8'h10, 8'h00, 8'h00});
    put(16'h10, '{8'h13, 8'h00, 8'h0D, 8'h73, 8'h00, 8'h73});
    run_prog("P4", 16'hD00, 16'hD08);
    chk("R9", "set R14 keeps its own value", 32'(w16(16'hD00)), 32'h0100);
    chk("R2", "jump by setting R15", 32'(dm[16'hD01]), 32'h01);
    chk("R12", "no write after break", 32'(dm[16'hD02]), 32'h00);
    chk("R12", "halt held", 32'(halt), 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule